// File: doc/BRIEF.md
# Multi-Mode Program Bank Mapper

This block sits between a CPU address bus and two kinds of program storage: a ROM of up to 1 MB and a work RAM of up to 64 KB built from two 32 KB chips. It watches CPU addresses from $6000 to $FFFF and turns each one into a physical ROM address with a ROM enable, or a RAM address with one chip select. Outside that range it enables nothing. The CPU sets it up by writing bytes to a small register window from $5100 to $5117.

The $6000-$7FFF window always maps one 8 KB RAM page. The $8000-$FFFF half is cut into one, two, three or four windows, depending on a two-bit layout setting. Each window that can hold RAM takes bit 7 of its bank byte to choose ROM (1) or RAM (0). The last window always maps ROM. When a window is wider than 8 KB, the low bank bits it cannot use are replaced by CPU address bits. RAM writes pass only when two protect registers hold a fixed key. All address outputs are combinational from the CPU address and the registers. Register writes take effect at the rising clock edge.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the layout is four 8 KB windows and all four bank bytes are $FF, so $E000-$FFFF maps ROM bank $7F (for example, CPU $E123 gives ROM address $FE123), and the RAM bank byte and both protect registers are 0.
- R2: Layout 0 (write $5100 with low bits 00) maps $8000-$FFFF as one 32 KB ROM window from the byte at $5117. ROM address = {bank[6:2], cpu[14:0]}.
- R3: Layout 1 uses the byte at $5115 for $8000-$BFFF and the byte at $5117 for $C000-$FFFF, each as 16 KB. ROM address = {bank[6:1], cpu[13:0]}. Bits 7:2 of $5100 are ignored.
- R4: Layout 2 uses $5115 as 16 KB at $8000-$BFFF, $5116 as 8 KB at $C000-$DFFF, and $5117 as 8 KB at $E000-$FFFF. An 8 KB ROM address = {bank[6:0], cpu[12:0]}.
- R5: Layout 3 maps $8000, $A000, $C000 and $E000 as 8 KB windows from $5114, $5115, $5116 and $5117 in that order.
- R6: $6000-$7FFF always maps RAM from the byte at $5113. Bit 2 picks the chip (ramCs bit 0 or bit 1), bits 1:0 pick the page, and ramAddr = {page, cpu[12:0]}. romCe is low there.
- R7: In $5114-$5116, bit 7 = 0 maps the window to RAM, with the bank bits decoded as in R6. In a 16 KB RAM window, page bit 0 comes from cpu[13]. Bit 7 of $5117 is ignored, and that window is always ROM.
- R8: ramWe is high only for a valid CPU write into a RAM-mapped window while $5102[1:0] = 2'b10 and $5103[1:0] = 2'b01. Upper protect bits are ignored.
- R9: Writes to $E000-$FFFF never raise ramWe. Addresses below $6000 raise neither romCe nor any ramCs bit. romCe and ramCs are never active together.
- R10: A bank byte whose window does not exist in the current layout has no effect. For example, $5114 in layout 1 and $5116 in layout 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | CPU bus cycle is valid |
| cpuWrite | input | 1 | CPU cycle is a write |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data for registers |
| romAddr | output | 20 | Physical ROM byte address |
| romCe | output | 1 | ROM enable |
| ramAddr | output | 15 | Address inside the selected RAM chip |
| ramCs | output | 2 | One-hot RAM chip select |
| ramWe | output | 1 | RAM write enable |

## Verification
The hardest case to reach is a RAM write through an upper window. The bench must first set the layout, then clear bit 7 of a bank byte, and then complete both halves of the protect key before it writes into $8000-$DFFF. A wrong key, a half key, or a write aimed at the always-ROM window must all leave ramWe low. The bench therefore builds the key one register at a time and probes the write after each step. It also probes 16 KB RAM windows at both halves, so that the address-bit substitution into the page field can be seen on ramAddr.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int CPU_AW = 16;
  localparam int DATA_W = 8;
  localparam int NUM_WIN = 4;

  typedef enum logic [1:0] {
    LAYOUT_32K = 2'd0,
    LAYOUT_16K = 2'd1,
    LAYOUT_MIX = 2'd2,
    LAYOUT_8K  = 2'd3
  } prgLayout_e;

  typedef struct packed {
    logic               wrLayout;
    logic               wrRamBank;
    logic [NUM_WIN-1:0] wrBank;
    logic               keyOk;
    logic               busWrite;
  } prgStrobe_t;
endpackage

// File: rtl/prg_ctrl.sv
module prg_ctrl
  import prg_map_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  output prgStrobe_t        strobe
);
  localparam logic [CPU_AW-6:0] REG_PAGE = 11'h288;  // $5100-$511F
  localparam logic [4:0] OFS_LAYOUT = 5'h00;
  localparam logic [4:0] OFS_KEY_A  = 5'h02;
  localparam logic [4:0] OFS_KEY_B  = 5'h03;
  localparam logic [4:0] OFS_RAMBK  = 5'h13;
  localparam logic [4:0] OFS_BANK0  = 5'h14;

  logic       regHit;
  logic [4:0] ofs;
  logic [1:0] keyA, keyB;

  assign regHit = cpuValid && cpuWrite && (cpuAddr[CPU_AW-1:5] == REG_PAGE);
  assign ofs    = cpuAddr[4:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyA <= '0;
      keyB <= '0;
    end else if (regHit) begin
      if (ofs == OFS_KEY_A) keyA <= cpuData[1:0];
      if (ofs == OFS_KEY_B) keyB <= cpuData[1:0];
    end
  end

  always_comb begin
    strobe.wrLayout  = regHit && (ofs == OFS_LAYOUT);
    strobe.wrRamBank = regHit && (ofs == OFS_RAMBK);
    strobe.keyOk     = (keyA == 2'b10) && (keyB == 2'b01);
    strobe.busWrite  = cpuValid && cpuWrite;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_bankStb
    assign strobe.wrBank[w] = regHit && (ofs == OFS_BANK0 + 5'(w));
  end
endmodule

// File: rtl/prg_datapath.sv
module prg_datapath
  import prg_map_pkg::*;
#(
  parameter int ROM_AW     = 20,
  parameter int RAM_CHIPS  = 2,
  parameter int RAM_PAGE_W = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  prgStrobe_t                   strobe,
  input  logic [CPU_AW-1:0]            cpuAddr,
  input  logic [DATA_W-1:0]            cpuData,
  output logic [ROM_AW-1:0]            romAddr,
  output logic                         romCe,
  output logic [RAM_PAGE_W+12:0]       ramAddr,
  output logic [RAM_CHIPS-1:0]         ramCs,
  output logic                         ramWe
);
  localparam int WIN_AW = 13;
  localparam int BANK_W = ROM_AW - WIN_AW;
  localparam int CHIP_W = (RAM_CHIPS > 1) ? $clog2(RAM_CHIPS) : 1;
  localparam int RSEL_W = RAM_PAGE_W + CHIP_W;

  prgLayout_e        layout;
  logic [DATA_W-1:0] bankReg [NUM_WIN];
  logic [RSEL_W-1:0] ramBankReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      layout     <= LAYOUT_8K;
      ramBankReg <= '0;
    end else begin
      if (strobe.wrLayout)  layout     <= prgLayout_e'(cpuData[1:0]);
      if (strobe.wrRamBank) ramBankReg <= cpuData[RSEL_W-1:0];
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)                bankReg[w] <= '1;
      else if (strobe.wrBank[w]) bankReg[w] <= cpuData;
    end
  end

  logic              inLow, inHigh, isRom, ramSel;
  logic [1:0]        winSel;
  logic [1:0]        span;   // 0: 8K, 1: 16K, 2: 32K
  logic [DATA_W-1:0] bankVal;
  logic [BANK_W-1:0] effBank;
  logic [RSEL_W-1:0] ramSelBits;
  logic [CHIP_W-1:0] chipIdx;

  assign inLow  = (cpuAddr[15:13] == 3'b011);
  assign inHigh = cpuAddr[15];

  always_comb begin
    winSel = 2'd3;
    span   = 2'd0;
    unique case (layout)
      LAYOUT_32K: begin winSel = 2'd3; span = 2'd2; end
      LAYOUT_16K: begin winSel = cpuAddr[14] ? 2'd3 : 2'd1; span = 2'd1; end
      LAYOUT_MIX: begin
        if (!cpuAddr[14]) begin winSel = 2'd1; span = 2'd1; end
        else begin winSel = cpuAddr[13] ? 2'd3 : 2'd2; span = 2'd0; end
      end
      LAYOUT_8K:  begin winSel = cpuAddr[14:13]; span = 2'd0; end
      default:    begin winSel = 2'd3; span = 2'd0; end
    endcase
  end

  always_comb begin
    bankVal = bankReg[winSel];
    isRom   = (winSel == 2'd3) || bankVal[DATA_W-1];
    effBank = bankVal[BANK_W-1:0];
    if (span != 2'd0) effBank[0] = cpuAddr[13];
    if (span == 2'd2) effBank[1] = cpuAddr[14];
    ramSelBits = inLow ? ramBankReg : effBank[RSEL_W-1:0];
    chipIdx    = ramSelBits[RSEL_W-1:RAM_PAGE_W];
  end

  assign romCe   = inHigh && isRom;
  assign romAddr = {effBank, cpuAddr[WIN_AW-1:0]};
  assign ramSel  = inLow || (inHigh && !isRom);
  assign ramAddr = {ramSelBits[RAM_PAGE_W-1:0], cpuAddr[WIN_AW-1:0]};
  assign ramWe   = ramSel && strobe.busWrite && strobe.keyOk &&
                   !(cpuAddr[15:13] == 3'b111);

  for (genvar c = 0; c < RAM_CHIPS; c++) begin : g_chip
    assign ramCs[c] = ramSel && (chipIdx == CHIP_W'(c));
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int ROM_AW     = 20,
  parameter int RAM_CHIPS  = 2,
  parameter int RAM_PAGE_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuValid,
  input  logic                   cpuWrite,
  input  logic [15:0]            cpuAddr,
  input  logic [7:0]             cpuData,
  output logic [ROM_AW-1:0]      romAddr,
  output logic                   romCe,
  output logic [RAM_PAGE_W+12:0] ramAddr,
  output logic [RAM_CHIPS-1:0]   ramCs,
  output logic                   ramWe
);
  prgStrobe_t strobe;

  prg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuData(cpuData), .strobe(strobe)
  );

  prg_datapath #(.ROM_AW(ROM_AW), .RAM_CHIPS(RAM_CHIPS), .RAM_PAGE_W(RAM_PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .romAddr(romAddr), .romCe(romCe), .ramAddr(ramAddr), .ramCs(ramCs), .ramWe(ramWe)
  );
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int ROM_AW     = 20,
  parameter int RAM_CHIPS  = 2,
  parameter int RAM_PAGE_W = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cpuValid,
  input logic                   cpuWrite,
  input logic [15:0]            cpuAddr,
  input logic [ROM_AW-1:0]      romAddr,
  input logic                   romCe,
  input logic [RAM_PAGE_W+12:0] ramAddr,
  input logic [RAM_CHIPS-1:0]   ramCs,
  input logic                   ramWe
);
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ramCs) && !(romCe && (ramCs != '0)));

  assert_below_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr < 16'h6000) |-> (!romCe && ramCs == '0 && !ramWe));

  assert_ram_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:13] == 3'b011) |-> (!romCe && ramCs != '0 && ramAddr[12:0] == cpuAddr[12:0]));

  assert_top_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:13] == 3'b111) |-> (romCe && !ramWe && romAddr[12:0] == cpuAddr[12:0]));

  assert_we_needs_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (cpuValid && cpuWrite && ramCs != '0));
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
  .ROM_AW(ROM_AW), .RAM_CHIPS(RAM_CHIPS), .RAM_PAGE_W(RAM_PAGE_W)
) u_chk (.*);

// File: tb/sim_prg_bank_mapper.sv
`timescale 1ns/1ps
module sim_prg_bank_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic [19:0] romAddr;
  logic        romCe;
  logic [14:0] ramAddr;
  logic [1:0]  ramCs;
  logic        ramWe;

  always #2.5 clk = ~clk;

  prg_bank_mapper u0 (.*);

  typedef struct {
    logic        romCe;
    logic [19:0] romAddr;
    logic [1:0]  ramCs;
    logic [14:0] ramAddr;
    logic        ramWe;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  event     sampleEv;
  int       checks = 0, fails = 0;
  bit       done = 0;

  task automatic wrReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuValid = 1; cpuWrite = 1; cpuAddr = a; cpuData = d;
    @(negedge clk);
    cpuValid = 0; cpuWrite = 0;
  endtask

  task automatic probe(input logic [15:0] a, input logic wr, input logic eRomCe,
                       input logic [19:0] eRom, input logic [1:0] eCs,
                       input logic [14:0] eRam, input logic eWe, input string tag);
    expItem_t it;
    @(negedge clk);
    cpuValid = 1; cpuWrite = wr; cpuAddr = a; cpuData = 8'h00;
    #1;
    it.romCe = eRomCe; it.romAddr = eRom; it.ramCs = eCs;
    it.ramAddr = eRam; it.ramWe = eWe; it.tag = tag;
    expQ.push_back(it);
    -> sampleEv;
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t e;
        bit bad;
        e = expQ.pop_front();
        checks++;
        bad = (romCe !== e.romCe) || (e.romCe && romAddr !== e.romAddr) ||
              (ramCs !== e.ramCs) || ((e.ramCs != 0) && ramAddr !== e.ramAddr) ||
              (ramWe !== e.ramWe);
        if (bad) begin
          fails++;
          $display("FAIL %s: got romCe=%b romAddr=%h ramCs=%b ramAddr=%h ramWe=%b exp romCe=%b romAddr=%h ramCs=%b ramAddr=%h ramWe=%b",
                   e.tag, romCe, romAddr, ramCs, ramAddr, ramWe,
                   e.romCe, e.romAddr, e.ramCs, e.ramAddr, e.ramWe);
        end
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    probe(16'hE123, 0, 1, 20'hFE123, 2'b00, 15'h0, 0, "R1 top window at reset");
    probe(16'h8010, 0, 1, 20'hFE010, 2'b00, 15'h0, 0, "R1 $8000 window at reset");
    probe(16'h6004, 1, 0, 20'h0, 2'b01, 15'h0004, 0, "R1 ram bank 0, key clear");
    // R9 below window
    probe(16'h5000, 0, 0, 20'h0, 2'b00, 15'h0, 0, "R9 below $6000 read");
    // R2 layout 0
    wrReg(16'h5100, 8'h00);
    wrReg(16'h5117, 8'h8B);
    probe(16'h9234, 0, 1, 20'h11234, 2'b00, 15'h0, 0, "R2 32K low half");
    probe(16'hF00F, 0, 1, 20'h1700F, 2'b00, 15'h0, 0, "R2 32K high half");
    // R3 layout 1, upper layout bits ignored
    wrReg(16'h5100, 8'hFD);
    wrReg(16'h5115, 8'h85);
    probe(16'hA001, 0, 1, 20'h0A001, 2'b00, 15'h0, 0, "R3 16K $8000 window upper");
    probe(16'h8001, 0, 1, 20'h08001, 2'b00, 15'h0, 0, "R3 16K $8000 window lower");
    probe(16'hD555, 0, 1, 20'h15555, 2'b00, 15'h0, 0, "R3 16K $C000 window");
    // R10 absent windows ignored
    wrReg(16'h5114, 8'h80);
    wrReg(16'h5116, 8'h80);
    probe(16'h8001, 0, 1, 20'h08001, 2'b00, 15'h0, 0, "R10 $5114 ignored in layout 1");
    probe(16'hC000, 0, 1, 20'h14000, 2'b00, 15'h0, 0, "R10 $5116 ignored in layout 1");
    // R4 layout 2
    wrReg(16'h5100, 8'h02);
    wrReg(16'h5116, 8'h93);
    probe(16'hB000, 0, 1, 20'h0B000, 2'b00, 15'h0, 0, "R4 16K window");
    probe(16'hC010, 0, 1, 20'h26010, 2'b00, 15'h0, 0, "R4 8K $C000 window");
    probe(16'hE004, 0, 1, 20'h16004, 2'b00, 15'h0, 0, "R4 8K $E000 window");
    // R5 layout 3
    wrReg(16'h5100, 8'h03);
    wrReg(16'h5114, 8'hA1);
    probe(16'h8100, 0, 1, 20'h42100, 2'b00, 15'h0, 0, "R5 window 0");
    probe(16'hA200, 0, 1, 20'h0A200, 2'b00, 15'h0, 0, "R5 window 1");
    probe(16'hC300, 0, 1, 20'h26300, 2'b00, 15'h0, 0, "R5 window 2");
    probe(16'hE400, 0, 1, 20'h16400, 2'b00, 15'h0, 0, "R5 window 3");
    // R6 RAM window
    wrReg(16'h5113, 8'h06);
    probe(16'h6ABC, 0, 0, 20'h0, 2'b10, 15'h4ABC, 0, "R6 chip 1 page 2");
    wrReg(16'h5113, 8'h01);
    probe(16'h7FFF, 0, 0, 20'h0, 2'b01, 15'h3FFF, 0, "R6 chip 0 page 1");
    // R8 key sequence
    probe(16'h6000, 1, 0, 20'h0, 2'b01, 15'h2000, 0, "R8 no key");
    wrReg(16'h5102, 8'h02);
    probe(16'h6000, 1, 0, 20'h0, 2'b01, 15'h2000, 0, "R8 half key");
    wrReg(16'h5103, 8'h01);
    probe(16'h6000, 1, 0, 20'h0, 2'b01, 15'h2000, 1, "R8 full key");
    probe(16'h6000, 0, 0, 20'h0, 2'b01, 15'h2000, 0, "R8 read no we");
    wrReg(16'h5102, 8'hFE);
    probe(16'h6001, 1, 0, 20'h0, 2'b01, 15'h2001, 1, "R8 upper key bits ignored");
    // R7 RAM in upper windows
    wrReg(16'h5114, 8'h05);
    probe(16'h9001, 1, 0, 20'h0, 2'b10, 15'h3001, 1, "R7 8K RAM window write");
    wrReg(16'h5117, 8'h0B);
    probe(16'hE004, 1, 1, 20'h16004, 2'b00, 15'h0, 0, "R7 $5117 bit7 ignored, R9 no we");
    wrReg(16'h5100, 8'h02);
    wrReg(16'h5115, 8'h06);
    probe(16'hA123, 0, 0, 20'h0, 2'b10, 15'h6123, 0, "R7 16K RAM upper page");
    probe(16'h8123, 1, 0, 20'h0, 2'b10, 15'h4123, 1, "R7 16K RAM lower page");
    wrReg(16'h5115, 8'h07);
    probe(16'h8123, 0, 0, 20'h0, 2'b10, 15'h4123, 0, "R7 16K RAM low bit ignored");
    // R9 writes
    probe(16'h5000, 1, 0, 20'h0, 2'b00, 15'h0, 0, "R9 write below $6000");
    wrReg(16'h5103, 8'h03);
    probe(16'h6000, 1, 0, 20'h0, 2'b01, 15'h2000, 0, "R8 key broken");
    @(negedge clk);
    cpuValid = 0; cpuWrite = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule